// File: doc/BRIEF.md
# Hart Load/Store Bus Router

This block sits between a hart's load/store unit and the memory system. It accepts one request per cycle. Each request carries an address, a size code, write data and a write flag. The block sends the request to one of three targets:

- a local RAM organised as 32-bit words,
- a small testbench I/O window,
- no target at all, which is reported as a fault.

One clock later it returns a response: a valid pulse, a fault flag and read data.

Byte and halfword accesses to the RAM use lane selection. A narrow store merges only its own lanes into the stored word and leaves the other bytes untouched. The RAM window has priority: an address inside it is always served by the RAM, even when the I/O window covers the same address. The I/O window has no storage. Its three word-write slots produce single-cycle strobes:

- a character strobe carrying the low byte,
- a hex-print strobe carrying the full word,
- an exit strobe carrying the word as an exit code.

Callers present only naturally aligned accesses. Alignment is not checked here. The RAM base, size and the I/O base are parameters. The RAM size may be zero. The default size is kept small so that elaboration stays light, and a full-size build sets it to 16 MiB.

Top module: `hart_bus_router`

## Requirements
- R1: Every cycle with `req_valid` high at a rising edge produces exactly one `rsp_valid` pulse at the next edge. A cycle without a request gives `rsp_valid` low. After reset all outputs are zero.
- R2: The RAM window is the half-open range [RAM_BASE, RAM_BASE+RAM_BYTES) on the unsigned address, and every RAM word reads as zero after reset.
- R3: A word write (size code 2) to the RAM, followed by a word read of the same address, returns the written value without fault. A write response carries zero read data.
- R4: A byte read (size code 0) returns the byte in lane addr[1:0] (lane 0 = bits 7:0) in bits 7:0, with bits 31:8 zero.
- R5: A halfword read (size code 1) returns bits 15:0 of the word when addr[1]=0 and bits 31:16 when addr[1]=1, placed in bits 15:0, with bits 31:16 zero.
- R6: A byte or halfword store replaces only the addressed lane(s) with the low bits of the write data and leaves the other bytes of the word unchanged.
- R7: Where the RAM window overlaps the I/O window, the access goes to the RAM and no I/O strobe fires.
- R8: In the I/O window (base IO_BASE, 12 bytes), a word write produces a strobe in the response cycle, and at most one strobe is high at a time:
  - offset 0 raises `char_stb` with `char_byte` = wdata[7:0],
  - offset 4 raises `hex_stb` with `hex_word` = wdata,
  - offset 8 raises `exit_stb` with `exit_code` = wdata.
- R9: Reads and byte/halfword writes to the I/O window fault with zero read data and no strobe.
- R10: An access outside all windows faults with zero read data, raises no strobe and changes no RAM word.
- R11: Size code 3 is reserved. It always faults, and a write with it leaves the RAM unchanged.
- R12: The last word of each window is accepted, and a word at the first address past it faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address, naturally aligned |
| req_wdata | input | 32 | Store data, low-aligned |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_fault | output | 1 | Access was refused |
| rsp_rdata | output | 32 | Load data, zero-extended; zero on fault or store |
| char_stb | output | 1 | Character print strobe |
| char_byte | output | 8 | Character to print |
| hex_stb | output | 1 | Hex print strobe |
| hex_word | output | 32 | Word to print in hex |
| exit_stb | output | 1 | Exit request strobe |
| exit_code | output | 32 | Exit code |

## Verification
A corrupted RAM lane or a wrong byte-enable stays hidden until a later load of that word. It then shows as a wrong byte in `rsp_rdata` on the cycle after that load. For this reason the vectors follow each narrow store with word and narrow reads of the same word. A decode error shows at once: the very next `rsp_fault` or strobe is wrong, one clock after the request. Boundary words, a second instance with overlapping windows, and reserved-size stores followed by read-back cover the priority and no-side-effect rules.

// File: rtl/busrt_pkg.sv
package busrt_pkg;
   localparam int WORD_W  = 32;
   localparam int LANES   = WORD_W / 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   // byte lanes touched by an access of a given size at lane offset
   function automatic logic [LANES-1:0] lane_enables(input logic [1:0] sz, input logic [1:0] lane);
      logic [LANES-1:0] be;
      case (sz)
         SZ_BYTE: be = LANES'(1) << lane;
         SZ_HALF: be = lane[1] ? 4'b1100 : 4'b0011;
         SZ_WORD: be = 4'b1111;
         default: be = 4'b0000;
      endcase
      return be;
   endfunction
endpackage

// File: rtl/busrt_decode.sv
module busrt_decode #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RAM_BASE  = '0,
   parameter int unsigned       RAM_BYTES = 256,
   parameter logic [ADDR_W-1:0] IO_BASE   = '0,
   parameter int unsigned       IO_BYTES  = 12,
   parameter int                IDX_W     = 6,
   parameter int                OFF_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ram_sel,
   output logic              io_sel,
   output logic [IDX_W-1:0]  ram_idx,
   output logic [OFF_W-1:0]  io_off
);
   localparam logic [ADDR_W:0] RAM_LO = {1'b0, RAM_BASE};
   localparam logic [ADDR_W:0] RAM_HI = RAM_LO + (ADDR_W+1)'(RAM_BYTES);
   localparam logic [ADDR_W:0] IO_LO  = {1'b0, IO_BASE};
   localparam logic [ADDR_W:0] IO_HI  = IO_LO + (ADDR_W+1)'(IO_BYTES);

   logic [ADDR_W:0] a_ext;
   logic            ram_hit, io_hit;

   assign a_ext = {1'b0, addr};

   generate
      if (RAM_BYTES == 0) begin : g_no_ram
         assign ram_hit = 1'b0;
      end else begin : g_ram_win
         assign ram_hit = (a_ext >= RAM_LO) && (a_ext < RAM_HI);
      end
   endgenerate

   assign io_hit  = (a_ext >= IO_LO) && (a_ext < IO_HI);
   // RAM window wins over anything else mapped at the same address
   assign ram_sel = ram_hit;
   assign io_sel  = io_hit && !ram_hit;
   assign ram_idx = IDX_W'((addr - RAM_BASE) >> 2);
   assign io_off  = OFF_W'(addr - IO_BASE);
endmodule

// File: rtl/busrt_ram.sv
module busrt_ram
   import busrt_pkg::*;
#(
   parameter int WORDS = 64,
   parameter int IDX_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              write,
   input  logic [1:0]        size,
   input  logic [1:0]        lane,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   generate
      if (WORDS == 0) begin : g_empty
         assign rdata = '0;
      end else begin : g_mem
         logic [WORD_W-1:0] mem [WORDS];
         logic [WORD_W-1:0] rd_q;
         logic [LANES-1:0]  be;
         logic [WORD_W-1:0] bmask;
         logic [WORD_W-1:0] wpos;
         logic [WORD_W-1:0] cur;
         logic [WORD_W-1:0] merged;
         logic [WORD_W-1:0] shifted;
         logic [WORD_W-1:0] extract;

         assign be  = lane_enables(size, lane);
         assign cur = mem[idx];

         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign bmask[8*l +: 8] = {8{be[l]}};
         end

         always_comb begin
            case (size)
               SZ_BYTE: wpos = {LANES{wdata[7:0]}};
               SZ_HALF: wpos = {2{wdata[15:0]}};
               default: wpos = wdata;
            endcase
         end

         // clear the target lanes then OR in the placed data
         assign merged = (cur & ~bmask) | (wpos & bmask);

         always_comb begin
            case (size)
               SZ_BYTE: begin
                  shifted = cur >> {lane, 3'b000};
                  extract = {24'b0, shifted[7:0]};
               end
               SZ_HALF: begin
                  shifted = cur >> {lane[1], 4'b0000};
                  extract = {16'b0, shifted[15:0]};
               end
               default: begin
                  shifted = cur;
                  extract = cur;
               end
            endcase
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < WORDS; i++) mem[i] <= '0;
               rd_q <= '0;
            end else if (en) begin
               if (write) mem[idx] <= merged;
               else       rd_q     <= extract;
            end
         end

         assign rdata = rd_q;

         // R6
         store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && write) |=> (((mem[$past(idx)] ^ $past(cur)) & ~$past(bmask)) == '0));
      end
   endgenerate
endmodule

// File: rtl/busrt_tbio.sv
module busrt_tbio
   import busrt_pkg::*;
#(
   parameter int OFF_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              fire,
   input  logic              write,
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  off,
   input  logic [WORD_W-1:0] wdata,
   output logic              accept,
   output logic              char_stb,
   output logic [7:0]        char_byte,
   output logic              hex_stb,
   output logic [WORD_W-1:0] hex_word,
   output logic              exit_stb,
   output logic [WORD_W-1:0] exit_code
);
   localparam logic [OFF_W-1:0] OFF_CHAR = OFF_W'(0);
   localparam logic [OFF_W-1:0] OFF_HEX  = OFF_W'(4);
   localparam logic [OFF_W-1:0] OFF_EXIT = OFF_W'(8);

   logic word_wr, hit_char, hit_hex, hit_exit;

   assign word_wr  = sel && write && (size == SZ_WORD);
   assign hit_char = word_wr && (off == OFF_CHAR);
   assign hit_hex  = word_wr && (off == OFF_HEX);
   assign hit_exit = word_wr && (off == OFF_EXIT);
   assign accept   = hit_char || hit_hex || hit_exit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         char_stb  <= 1'b0;
         hex_stb   <= 1'b0;
         exit_stb  <= 1'b0;
         char_byte <= '0;
         hex_word  <= '0;
         exit_code <= '0;
      end else begin
         char_stb <= fire && hit_char;
         hex_stb  <= fire && hit_hex;
         exit_stb <= fire && hit_exit;
         if (fire && hit_char) char_byte <= wdata[7:0];
         if (fire && hit_hex)  hex_word  <= wdata;
         if (fire && hit_exit) exit_code <= wdata;
      end
   end

   // R8
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({char_stb, hex_stb, exit_stb}));
endmodule

// File: rtl/hart_bus_router.sv
module hart_bus_router
   import busrt_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RAM_BASE  = '0,
   parameter int unsigned       RAM_BYTES = 256,
   parameter logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(32'h8000_0000),
   parameter int unsigned       IO_BYTES  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [31:0]       rsp_rdata,
   output logic              char_stb,
   output logic [7:0]        char_byte,
   output logic              hex_stb,
   output logic [31:0]       hex_word,
   output logic              exit_stb,
   output logic [31:0]       exit_code
);
   localparam int WORDS = int'(RAM_BYTES / 4);
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int OFF_W = (IO_BYTES > 1) ? $clog2(IO_BYTES) : 1;

   generate
      if (RAM_BYTES % 4 != 0) begin : g_bad_ram_size
         $error("RAM_BYTES must be a multiple of 4");
      end
      if (RAM_BASE[1:0] != 2'b00) begin : g_bad_ram_base
         $error("RAM_BASE must be word aligned");
      end
      if (IO_BYTES < 12) begin : g_bad_io_size
         $error("IO_BYTES must cover three word slots");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W too narrow");
      end
   endgenerate

   logic             ram_sel, io_sel, io_accept, size_ok, ram_ok, ok;
   logic [IDX_W-1:0] ram_idx;
   logic [OFF_W-1:0] io_off;
   logic [31:0]      ram_rdata;
   logic             rsp_valid_q, rsp_fault_q, rd_ram_q;

   busrt_decode #(
      .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
      .IO_BASE(IO_BASE), .IO_BYTES(IO_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) u_decode (
      .addr(req_addr), .ram_sel(ram_sel), .io_sel(io_sel),
      .ram_idx(ram_idx), .io_off(io_off)
   );

   assign size_ok = (req_size != SZ_RSVD);
   assign ram_ok  = ram_sel && size_ok;
   assign ok      = ram_ok || io_accept;

   busrt_ram #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .en(req_valid && ram_ok), .write(req_write),
      .size(req_size), .lane(req_addr[1:0]), .idx(ram_idx),
      .wdata(req_wdata), .rdata(ram_rdata)
   );

   busrt_tbio #(.OFF_W(OFF_W)) u_tbio (
      .clk(clk), .rst_n(rst_n), .sel(io_sel), .fire(req_valid && io_sel),
      .write(req_write), .size(req_size), .off(io_off), .wdata(req_wdata),
      .accept(io_accept), .char_stb(char_stb), .char_byte(char_byte),
      .hex_stb(hex_stb), .hex_word(hex_word), .exit_stb(exit_stb),
      .exit_code(exit_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_fault_q <= 1'b0;
         rd_ram_q    <= 1'b0;
      end else begin
         rsp_valid_q <= req_valid;
         rsp_fault_q <= req_valid && !ok;
         rd_ram_q    <= req_valid && ram_ok && !req_write;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_fault = rsp_fault_q;
   assign rsp_rdata = rd_ram_q ? ram_rdata : '0;

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R10
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_valid && rsp_rdata == '0 && !char_stb && !hex_stb && !exit_stb));
   // R8
   strobe_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb || hex_stb || exit_stb) |-> (rsp_valid && !rsp_fault));
endmodule

// File: tb/hart_bus_router_bench.sv
module hart_bus_router_bench;
   localparam time CLK_P = 5ns;

   typedef struct packed {
      int          rq;
      logic        wr;
      logic [1:0]  sz;
      logic [31:0] ad;
      logic [31:0] wd;
      logic        ef;
      logic [31:0] er;
      logic [2:0]  es;   // {exit, hex, char}
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VECS [NV] = '{
      '{2,  1'b0, 2'd2, 32'h0000_0000, 32'h0,          1'b0, 32'h0,          3'b000}, // R2 reset zero
      '{2,  1'b0, 2'd2, 32'h0000_00F0, 32'h0,          1'b0, 32'h0,          3'b000}, // R2
      '{3,  1'b1, 2'd2, 32'h0000_0010, 32'h1122_3344,  1'b0, 32'h0,          3'b000}, // R3 write
      '{3,  1'b0, 2'd2, 32'h0000_0010, 32'h0,          1'b0, 32'h1122_3344,  3'b000}, // R3 read
      '{4,  1'b0, 2'd0, 32'h0000_0010, 32'h0,          1'b0, 32'h0000_0044,  3'b000}, // R4 lane0
      '{4,  1'b0, 2'd0, 32'h0000_0011, 32'h0,          1'b0, 32'h0000_0033,  3'b000}, // R4 lane1
      '{4,  1'b0, 2'd0, 32'h0000_0013, 32'h0,          1'b0, 32'h0000_0011,  3'b000}, // R4 lane3
      '{5,  1'b0, 2'd1, 32'h0000_0010, 32'h0,          1'b0, 32'h0000_3344,  3'b000}, // R5 low half
      '{5,  1'b0, 2'd1, 32'h0000_0012, 32'h0,          1'b0, 32'h0000_1122,  3'b000}, // R5 high half
      '{6,  1'b1, 2'd0, 32'h0000_0012, 32'hFFFF_FFAA,  1'b0, 32'h0,          3'b000}, // R6 byte store
      '{6,  1'b0, 2'd2, 32'h0000_0010, 32'h0,          1'b0, 32'h11AA_3344,  3'b000}, // R6
      '{6,  1'b1, 2'd1, 32'h0000_0010, 32'h1234_BEEF,  1'b0, 32'h0,          3'b000}, // R6 half store
      '{6,  1'b0, 2'd2, 32'h0000_0010, 32'h0,          1'b0, 32'h11AA_BEEF,  3'b000}, // R6
      '{6,  1'b0, 2'd1, 32'h0000_0012, 32'h0,          1'b0, 32'h0000_11AA,  3'b000}, // R6
      '{12, 1'b1, 2'd2, 32'h0000_00FC, 32'hCAFE_F00D,  1'b0, 32'h0,          3'b000}, // R12 last RAM word
      '{12, 1'b0, 2'd2, 32'h0000_00FC, 32'h0,          1'b0, 32'hCAFE_F00D,  3'b000}, // R12
      '{12, 1'b1, 2'd2, 32'h0000_0100, 32'h5555_5555,  1'b1, 32'h0,          3'b000}, // R12 past RAM
      '{10, 1'b0, 2'd2, 32'h0000_00FC, 32'h0,          1'b0, 32'hCAFE_F00D,  3'b000}, // R10 no side effect
      '{10, 1'b0, 2'd2, 32'h4000_0000, 32'h0,          1'b1, 32'h0,          3'b000}, // R10 miss read
      '{8,  1'b1, 2'd2, 32'h8000_0000, 32'h0000_0141,  1'b0, 32'h0,          3'b001}, // R8 char
      '{8,  1'b1, 2'd2, 32'h8000_0004, 32'hDEAD_BEEF,  1'b0, 32'h0,          3'b010}, // R8 hex
      '{8,  1'b1, 2'd2, 32'h8000_0008, 32'h0000_0007,  1'b0, 32'h0,          3'b100}, // R8 exit
      '{9,  1'b0, 2'd2, 32'h8000_0000, 32'h0,          1'b1, 32'h0,          3'b000}, // R9 io read
      '{9,  1'b1, 2'd0, 32'h8000_0000, 32'h0000_0041,  1'b1, 32'h0,          3'b000}, // R9 io byte write
      '{12, 1'b1, 2'd2, 32'h8000_000C, 32'h0000_0001,  1'b1, 32'h0,          3'b000}, // R12 past IO
      '{11, 1'b1, 2'd3, 32'h0000_0020, 32'h0000_0055,  1'b1, 32'h0,          3'b000}, // R11 reserved size
      '{11, 1'b0, 2'd2, 32'h0000_0020, 32'h0,          1'b0, 32'h0,          3'b000}  // R11 no write
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        rsp_valid, rsp_fault, char_stb, hex_stb, exit_stb;
   logic [31:0] rsp_rdata, hex_word, exit_code;
   logic [7:0]  char_byte;
   logic        o_valid, o_fault, o_char, o_hex, o_exit;
   logic [31:0] o_rdata, o_hexw, o_exitc;
   logic [7:0]  o_charb;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   hart_bus_router u_hart_bus_router (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
      .char_stb(char_stb), .char_byte(char_byte), .hex_stb(hex_stb),
      .hex_word(hex_word), .exit_stb(exit_stb), .exit_code(exit_code)
   );

   // RAM window placed on top of the I/O window
   hart_bus_router #(.RAM_BASE(32'h8000_0000), .RAM_BYTES(64)) u_hart_bus_router_ovl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(o_valid), .rsp_fault(o_fault), .rsp_rdata(o_rdata),
      .char_stb(o_char), .char_byte(o_charb), .hex_stb(o_hex),
      .hex_word(o_hexw), .exit_stb(o_exit), .exit_code(o_exitc)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic wr, input logic [1:0] sz, input logic [31:0] ad, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs zero in reset
      check("R1 reset", {rsp_valid, rsp_fault, char_stb, hex_stb, exit_stb, rsp_rdata},
            64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle", {63'h0, rsp_valid}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         logic [63:0] act, exp;
         issue(VECS[i].wr, VECS[i].sz, VECS[i].ad, VECS[i].wd);
         act = {rsp_valid, rsp_fault, exit_stb, hex_stb, char_stb, 27'h0, rsp_rdata};
         exp = {1'b1, VECS[i].ef, VECS[i].es, 27'h0, VECS[i].er};
         check($sformatf("R%0d vector %0d", VECS[i].rq, i), act, exp);
         // R8 strobe payloads
         if (VECS[i].es[0]) check("R8 char payload", {56'h0, char_byte}, {56'h0, VECS[i].wd[7:0]});
         if (VECS[i].es[1]) check("R8 hex payload", {32'h0, hex_word}, {32'h0, VECS[i].wd});
         if (VECS[i].es[2]) check("R8 exit payload", {32'h0, exit_code}, {32'h0, VECS[i].wd});
      end

      // R1 single pulse: one idle cycle after a response drops rsp_valid
      @(negedge clk);
      check("R1 pulse", {63'h0, rsp_valid}, 64'h0);

      // R7 overlap: write into the shared address goes to RAM, no strobe
      issue(1'b1, 2'd2, 32'h8000_0000, 32'h0BAD_F00D);
      check("R7 overlap write", {59'h0, o_valid, o_fault, o_char, o_hex, o_exit}, 64'b10000);
      check("R7 io side still strobes", {63'h0, char_stb}, 64'h1);
      issue(1'b0, 2'd2, 32'h8000_0000, 32'h0);
      check("R7 overlap read", {31'h0, o_valid, o_fault, o_rdata}, {31'h0, 1'b1, 1'b0, 32'h0BAD_F00D});

      // R1 back-to-back requests give back-to-back responses
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'h10; req_wdata = '0;
      @(negedge clk);
      req_addr = 32'hFC;
      check("R1 b2b first", {31'h0, rsp_valid, 32'h0, rsp_rdata} >> 0, {31'h0, 1'b1, 32'h0, 32'h11AA_BEEF});
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 b2b second", {31'h0, rsp_valid, rsp_rdata}, {31'h0, 1'b1, 32'hCAFE_F00D});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule